// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a bank of one-bit token flags that two independent requesters, called the left port and the right port, use to claim a shared resource. Each port addresses one flag with an index. A port asks for a flag by writing 0 to it and gives the flag back by writing 1. A port reads the flag to learn whether it holds the token. The read word is all zeros while the reading port holds the token, and all ones otherwise.

A request that arrives while the other port holds the token is not lost. It is stored as a pending request. When the holder releases the flag, the token passes straight to the waiting port, so that port does not need to poll and retry. A waiting port can withdraw its request by writing 1 before the grant. All state lives in registers on one shared clock, and the read words are combinational views of that state.

Top module: `sem_bank`

## Requirements
- R1: After reset every flag is free with no pending request, and both ports read 16'hFFFF at every index.
- R2: A port accesses the bank only while its `*_sem_en` is 1 and its `*_mem_en` is 0. Writes at any other time have no effect, and the port's read word is then 16'h0000.
- R3: A write of 0 to a free flag grants the token to the writer from the next clock edge. From then the writer reads 16'h0000 and the other port reads 16'hFFFF.
- R4: A write uses only bit 0 of `*_wdata` (0 requests, 1 releases). Bits 15:1 are ignored.
- R5: A write of 0 to a flag held by the other port leaves both read words unchanged and records a pending request.
- R6: When the holder writes 1 while the other port has a request pending, the token passes to the waiting port at that edge. The waiting port then reads 16'h0000 and the releasing port reads 16'hFFFF.
- R7: When the holder writes 1 and nothing is pending, the flag becomes free and both ports read 16'hFFFF.
- R8: A port that has a request pending and writes 1 withdraws that request, so a later release by the holder frees the flag.
- R9: If both ports write 0 to the same free flag in the same cycle, the left port is granted and the right port's request becomes pending.
- R10: The eight flags, indexed 0 to 7 by `*_idx`, are independent. An operation on one index never changes another.
- R11: A write of 0 by the holder, and a write of 1 by a non-holder that has nothing pending, leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_sem_en | input | 1 | Left port semaphore select (active high) |
| l_mem_en | input | 1 | Left port memory enable; must be 0 for a flag access |
| l_idx | input | 3 | Left port flag index |
| l_wr | input | 1 | Left port write strobe |
| l_wdata | input | 16 | Left port write data; only bit 0 is used |
| l_rdata | output | 16 | Left port read word |
| r_sem_en | input | 1 | Right port semaphore select (active high) |
| r_mem_en | input | 1 | Right port memory enable; must be 0 for a flag access |
| r_idx | input | 3 | Right port flag index |
| r_wr | input | 1 | Right port write strobe |
| r_wdata | input | 16 | Right port write data; only bit 0 is used |
| r_rdata | output | 16 | Right port read word |

## Verification
The bench builds the block with its default parameters: eight flags and a 16-bit read word. With these values every index, including both ends 0 and 7, can be addressed directly, so the bench can show independence across indices on the full bank. The full width of the read word is also exposed, which lets the bench check that ignored upper write bits never matter and that the replicated read value covers all sixteen bits.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } own_t;

  typedef struct packed {
    own_t owner;
    logic wait_l;
    logic wait_r;
  } flag_state_t;

  // Next state of one flag given this cycle's per-port request and release pulses.
  function automatic flag_state_t flag_next(
    input flag_state_t cur,
    input logic        l_req,
    input logic        l_rel,
    input logic        r_req,
    input logic        r_rel
  );
    flag_state_t nxt;
    logic want_l;
    logic want_r;
    want_l = (cur.wait_l | l_req) & ~l_rel;
    want_r = (cur.wait_r | r_req) & ~r_rel;
    nxt = cur;
    case (cur.owner)
      OWN_LEFT: begin
        nxt.wait_l = 1'b0;
        if (l_rel) begin
          nxt.owner  = want_r ? OWN_RIGHT : OWN_NONE;
          nxt.wait_r = 1'b0;
        end else begin
          nxt.wait_r = want_r;
        end
      end
      OWN_RIGHT: begin
        nxt.wait_r = 1'b0;
        if (r_rel) begin
          nxt.owner  = want_l ? OWN_LEFT : OWN_NONE;
          nxt.wait_l = 1'b0;
        end else begin
          nxt.wait_l = want_l;
        end
      end
      default: begin
        nxt.wait_l = 1'b0;
        nxt.wait_r = 1'b0;
        nxt.owner  = OWN_NONE;
        if (l_req) begin
          nxt.owner  = OWN_LEFT;
          nxt.wait_r = r_req;
        end else if (r_req) begin
          nxt.owner = OWN_RIGHT;
        end
      end
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sem_en,
  input  logic              mem_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              access,
  output logic [NUM_SEM-1:0] req_vec,
  output logic [NUM_SEM-1:0] rel_vec
);

  logic wbit;
  assign access = sem_en & ~mem_en;
  assign wbit   = wdata[0];

  generate
    for (genvar i = 0; i < NUM_SEM; i++) begin : g_sel
      logic hit;
      assign hit        = access & wr & (idx == IDX_W'(i));
      assign req_vec[i] = hit & ~wbit;
      assign rel_vec[i] = hit & wbit;
    end
  endgenerate

  // R10: a single write reaches at most one flag.
  a_r10_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_vec | rel_vec));

  // R2: without a valid access no flag sees a pulse.
  a_r2_gated_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(sem_en && !mem_en) |-> ((req_vec | rel_vec) == '0));

endmodule

// File: rtl/sem_flag.sv
module sem_flag
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output own_t owner
);

  flag_state_t cur, nxt;

  // Named events for the assertions.
  logic hand_to_r, hand_to_l, free_rel, tie_req;
  assign hand_to_r = (cur.owner == OWN_LEFT)  && l_rel && cur.wait_r && !r_rel;
  assign hand_to_l = (cur.owner == OWN_RIGHT) && r_rel && cur.wait_l && !l_rel;
  assign free_rel  = ((cur.owner == OWN_LEFT) && l_rel && !cur.wait_r && !r_req) ||
                     ((cur.owner == OWN_RIGHT) && r_rel && !cur.wait_l && !l_req);
  assign tie_req   = (cur.owner == OWN_NONE) && l_req && r_req;

  always_comb nxt = flag_next(cur, l_req, l_rel, r_req, r_rel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '{owner: OWN_NONE, wait_l: 1'b0, wait_r: 1'b0};
    end else begin
      cur <= nxt;
    end
  end

  assign owner = cur.owner;

  a_r1_free_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.owner == OWN_NONE) |-> (!cur.wait_l && !cur.wait_r));

  a_r6_pass_to_right: assert property (@(posedge clk) disable iff (!rst_n)
    hand_to_r |=> (owner == OWN_RIGHT));

  a_r6_pass_to_left: assert property (@(posedge clk) disable iff (!rst_n)
    hand_to_l |=> (owner == OWN_LEFT));

  a_r7_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    free_rel |=> (owner == OWN_NONE));

  a_r9_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tie_req |=> (owner == OWN_LEFT && cur.wait_r));

  a_r5_holder_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.owner == OWN_LEFT && !l_rel) |=> (owner == OWN_LEFT));

  a_r8_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.owner == OWN_LEFT && !l_rel && r_rel) |=> !cur.wait_r);

endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sem_en,
  input  logic              l_mem_en,
  input  logic [IDX_W-1:0]  l_idx,
  input  logic              l_wr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sem_en,
  input  logic              r_mem_en,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic              r_wr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);

  // All zeros when the reader holds the token, all ones otherwise.
  function automatic logic [DATA_W-1:0] read_word(input logic held);
    return {DATA_W{~held}};
  endfunction

  logic               l_access, r_access;
  logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
  own_t               owner [NUM_SEM];

  sem_port_decode #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_ldec (
    .clk(clk), .rst_n(rst_n), .sem_en(l_sem_en), .mem_en(l_mem_en),
    .idx(l_idx), .wr(l_wr), .wdata(l_wdata),
    .access(l_access), .req_vec(l_req), .rel_vec(l_rel)
  );

  sem_port_decode #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rdec (
    .clk(clk), .rst_n(rst_n), .sem_en(r_sem_en), .mem_en(r_mem_en),
    .idx(r_idx), .wr(r_wr), .wdata(r_wdata),
    .access(r_access), .req_vec(r_req), .rel_vec(r_rel)
  );

  generate
    for (genvar i = 0; i < NUM_SEM; i++) begin : g_flag
      sem_flag u_flag (
        .clk(clk), .rst_n(rst_n),
        .l_req(l_req[i]), .l_rel(l_rel[i]),
        .r_req(r_req[i]), .r_rel(r_rel[i]),
        .owner(owner[i])
      );
    end
  endgenerate

  logic l_held, r_held;
  assign l_held  = (owner[l_idx] == OWN_LEFT);
  assign r_held  = (owner[r_idx] == OWN_RIGHT);
  assign l_rdata = l_access ? read_word(l_held) : '0;
  assign r_rdata = r_access ? read_word(r_held) : '0;

  // R3: two ports reading one index never both see the token.
  a_r3_exclusive_read: assert property (@(posedge clk) disable iff (!rst_n)
    (l_access && r_access && l_idx == r_idx) |-> !(l_rdata == '0 && r_rdata == '0));

  // R2: a port that is not accessing reads zero.
  a_r2_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_access) |-> (l_rdata == '0));

endmodule

// File: tb/sem_bank_test.sv
module sem_bank_test;
  localparam int CLK_P = 10;
  localparam logic [15:0] ONES = 16'hFFFF;
  localparam logic [15:0] ZERO = 16'h0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sem_en = 0, l_mem_en = 0, l_wr = 0, r_sem_en = 0, r_mem_en = 0, r_wr = 0;
  logic [2:0] l_idx = 0, r_idx = 0;
  logic [15:0] l_wdata = 0, r_wdata = 0, l_rdata, r_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  sem_bank uut (
    .clk(clk), .rst_n(rst_n),
    .l_sem_en(l_sem_en), .l_mem_en(l_mem_en), .l_idx(l_idx), .l_wr(l_wr),
    .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_en(r_sem_en), .r_mem_en(r_mem_en), .r_idx(r_idx), .r_wr(r_wr),
    .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Both ports read one index; no clock edge needed.
  task automatic rd(input logic [2:0] idx, output logic [15:0] la, output logic [15:0] ra);
    l_sem_en = 1; l_mem_en = 0; l_wr = 0; l_idx = idx;
    r_sem_en = 1; r_mem_en = 0; r_wr = 0; r_idx = idx;
    #1;
    la = l_rdata; ra = r_rdata;
  endtask

  task automatic step(input logic lw, input logic lb, input logic [2:0] li,
                      input logic rw, input logic rb, input logic [2:0] ri);
    l_sem_en = 1; l_mem_en = 0; l_wr = lw; l_idx = li; l_wdata = {15'h0, lb};
    r_sem_en = 1; r_mem_en = 0; r_wr = rw; r_idx = ri; r_wdata = {15'h0, rb};
    @(posedge clk); #1;
    l_wr = 0; r_wr = 0;
  endtask

  // {lw, lb, li[2:0], rw, rb, ri[2:0], check_idx[2:0], l_held, r_held}
  typedef logic [14:0] vec_t;
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    {1'b1,1'b0,3'd0, 1'b0,1'b0,3'd0, 3'd0, 1'b1,1'b0},  // R3 left takes 0
    {1'b0,1'b0,3'd0, 1'b1,1'b0,3'd0, 3'd0, 1'b1,1'b0},  // R5 right waits
    {1'b1,1'b1,3'd0, 1'b0,1'b0,3'd0, 3'd0, 1'b0,1'b1},  // R6 pass to right
    {1'b0,1'b0,3'd0, 1'b1,1'b1,3'd0, 3'd0, 1'b0,1'b0},  // R7 free
    {1'b1,1'b0,3'd1, 1'b1,1'b0,3'd1, 3'd1, 1'b1,1'b0},  // R9 tie, left wins
    {1'b1,1'b1,3'd1, 1'b0,1'b0,3'd1, 3'd1, 1'b0,1'b1},  // R9 right pending gets it
    {1'b1,1'b0,3'd1, 1'b0,1'b0,3'd1, 3'd1, 1'b0,1'b1},  // R5 left waits
    {1'b1,1'b1,3'd1, 1'b0,1'b0,3'd1, 3'd1, 1'b0,1'b1},  // R8 left withdraws
    {1'b0,1'b0,3'd1, 1'b1,1'b1,3'd1, 3'd1, 1'b0,1'b0},  // R8 release frees
    {1'b0,1'b0,3'd7, 1'b1,1'b0,3'd7, 3'd7, 1'b0,1'b1},  // R3 right takes 7
    {1'b1,1'b0,3'd6, 1'b0,1'b0,3'd6, 3'd6, 1'b1,1'b0},  // R10 left takes 6
    {1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 3'd7, 1'b0,1'b1},  // R10 index 7 kept
    {1'b0,1'b0,3'd7, 1'b1,1'b0,3'd7, 3'd7, 1'b0,1'b1},  // R11 holder writes 0
    {1'b1,1'b1,3'd7, 1'b0,1'b0,3'd7, 3'd7, 1'b0,1'b1}   // R11 non-holder writes 1
  };

  initial begin
    logic [15:0] la, ra;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1: reset state at every index.
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), la, ra);
      chk("R1 left reset", la, ONES);
      chk("R1 right reset", ra, ONES);
    end

    for (int v = 0; v < NV; v++) begin
      vec_t e;
      e = VEC[v];
      step(e[14], e[13], e[12:10], e[9], e[8], e[7:5]);
      rd(e[4:2], la, ra);
      chk($sformatf("vector %0d left", v), la, e[1] ? ZERO : ONES);
      chk($sformatf("vector %0d right", v), ra, e[0] ? ZERO : ONES);
    end

    // R2: memory enable active blocks the write.
    l_sem_en = 1; l_mem_en = 1; l_idx = 3; l_wr = 1; l_wdata = 16'h0000;
    #1; chk("R2 idle read zero", l_rdata, ZERO);
    @(posedge clk); #1; l_wr = 0;
    // R2: semaphore select inactive blocks the write.
    l_sem_en = 0; l_mem_en = 0; l_wr = 1;
    @(posedge clk); #1; l_wr = 0;
    rd(3'd3, la, ra);
    chk("R2 left idx3 untouched", la, ONES);
    chk("R2 right idx3 untouched", ra, ONES);

    // R4: upper data bits ignored.
    l_sem_en = 1; l_mem_en = 0; l_idx = 2; l_wr = 1; l_wdata = 16'hFFFE;
    @(posedge clk); #1; l_wr = 0;
    rd(3'd2, la, ra);
    chk("R4 bit0=0 requests", la, ZERO);
    l_idx = 2; l_wr = 1; l_wdata = 16'h0001;
    @(posedge clk); #1; l_wr = 0;
    rd(3'd2, la, ra);
    chk("R4 bit0=1 releases", la, ONES);
    chk("R4 right sees free", ra, ONES);

    // R10: index 6 still held by left after all of the above.
    rd(3'd6, la, ra);
    chk("R10 left idx6 held", la, ZERO);

    // R1: reset clears held flags.
    rst_n = 1'b0; #1; rst_n = 1'b1; #1;
    rd(3'd6, la, ra);
    chk("R1 reset clears idx6", la, ONES);
    rd(3'd7, la, ra);
    chk("R1 reset clears idx7", ra, ONES);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule